// File: doc/BRIEF.md
# Carry-Save Tree Multioperand Adder

This block sums N unsigned K-bit operands that arrive together on one flat bus and returns their exact total. The operand set passes through layers of 3-to-2 carry-save stages. Each stage turns three equally weighted vectors into a sum vector and a carry vector that sits one bit further left. At every layer, as many whole groups of three as exist are compressed, and any one or two leftover vectors pass straight through. The number of layers is therefore the minimum height for N operands: each layer maps m vectors to ceil(2m/3), so seven operands take four layers (7, 5, 4, 3, 2).

When two vectors remain, one ripple-carry adder merges them. The result is captured in an output register that loads only while the input strobe is high. The result appears one clock after the strobe, together with a valid flag. The result is K + ceil(log2 N) bits wide, so the largest possible total, N·(2^K − 1), always fits. The default configuration is seven operands of six bits each, which gives a nine-bit result.

Top module: `mop_csa_tree_adder`

## Requirements
- R1: While rst_ni is low, and on the first clock after it is released with valid_i low, valid_o is 0 and sum_o is 0.
- R2: After a rising clock edge at which valid_i is high, sum_o equals the exact unsigned sum of the N operands sampled at that edge. Operand i occupies bits [i*K +: K] of operands_i.
- R3: sum_o never exceeds N·(2^K − 1). With every operand at 2^K − 1, sum_o equals that maximum (441 for seven six-bit operands) with no wrap.
- R4: valid_o is high in exactly those cycles that follow a rising edge at which valid_i was high.
- R5: After an edge at which valid_i is low, sum_o keeps its previous value, whatever the operand bus carries.
- R6: When valid_i is high on consecutive edges, each edge's operand set produces its own sum in the following cycle.
- R7: All-zero operands give a sum of 0, even directly after a non-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand set on operands_i is valid |
| operands_i | input | N*K | N unsigned operands, operand i at bits [i*K +: K] |
| valid_o | output | 1 | sum_o holds a new result |
| sum_o | output | K+clog2(N) | Registered sum of the last valid operand set |

## Verification
A table of operand sets targets specific features of the tree. All-ones operands produce the maximum total, and their carries ripple through every layer and across the full width. All-zero operands expose any stuck or leaked carry. An ascending set and an alternating max/zero set show whether a vector is routed to the wrong slot or dropped when it passes through a layer. Random operand sets are compared against a behavioural sum, and separate tests check register hold, back-to-back strobes and the output register's reset value.

// File: rtl/mop_pkg.sv
package mop_pkg;

  // vectors left after l carry-save layers, starting from n
  function automatic int level_count(input int n, input int l);
    int m;
    m = n;
    for (int i = 0; i < l; i++) m = m - m / 3;
    return m;
  endfunction

  // minimum layers to reach two vectors
  function automatic int tree_height(input int n);
    int m;
    int h;
    m = n;
    h = 0;
    while (m > 2) begin
      m = m - m / 3;
      h++;
    end
    return h;
  endfunction

  function automatic int sum_width(input int n, input int k);
    return k + $clog2(n);
  endfunction

endpackage

// File: rtl/csa_3to2.sv
module csa_3to2 #(
  parameter int W = 9
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  logic [W-2:0] maj;

  assign s_o = x_i ^ y_i ^ z_i;
  assign maj = (x_i[W-2:0] & y_i[W-2:0]) | (x_i[W-2:0] & z_i[W-2:0]) |
               (y_i[W-2:0] & z_i[W-2:0]);
  // carry weight is one position up; top carry cannot be set for an in-range sum
  assign c_o = {maj, 1'b0};
endmodule

// File: rtl/csa_level.sv
module csa_level #(
  parameter int W = 9,
  parameter int M = 7,
  localparam int G  = M / 3,
  localparam int R  = M % 3,
  localparam int MO = 2 * G + R
) (
  input  logic [M*W-1:0]  vec_i,
  output logic [MO*W-1:0] vec_o
);
  for (genvar g = 0; g < G; g++) begin : g_csa
    csa_3to2 #(.W(W)) u_csa (
      .x_i(vec_i[(3*g)*W   +: W]),
      .y_i(vec_i[(3*g+1)*W +: W]),
      .z_i(vec_i[(3*g+2)*W +: W]),
      .s_o(vec_o[(2*g)*W   +: W]),
      .c_o(vec_o[(2*g+1)*W +: W])
    );
  end

  for (genvar r = 0; r < R; r++) begin : g_pass
    assign vec_o[(2*G+r)*W +: W] = vec_i[(3*G+r)*W +: W];
  end
endmodule

// File: rtl/rca_adder.sv
module rca_adder #(
  parameter int W = 9
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] cy;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
    if (i < W - 1) begin : g_cy
      assign cy[i+1] = (a_i[i] & b_i[i]) | (a_i[i] & cy[i]) | (b_i[i] & cy[i]);
    end
  end
endmodule

// File: rtl/mop_csa_tree_adder.sv
module mop_csa_tree_adder
  import mop_pkg::*;
#(
  parameter int N = 7,
  parameter int K = 6,
  localparam int W = sum_width(N, K),
  localparam int H = tree_height(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [N*K-1:0] operands_i,
  output logic         valid_o,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] tree [0:H][0:N-1];
  logic [W-1:0] total;
  logic [W-1:0] sum_q;
  logic         valid_q;

  for (genvar i = 0; i < N; i++) begin : g_in
    assign tree[0][i] = {{(W-K){1'b0}}, operands_i[i*K +: K]};
  end

  for (genvar l = 0; l < H; l++) begin : g_lvl
    localparam int M  = level_count(N, l);
    localparam int MO = level_count(N, l + 1);
    logic [M*W-1:0]  lin;
    logic [MO*W-1:0] lout;

    for (genvar i = 0; i < M; i++) begin : g_pack
      assign lin[i*W +: W] = tree[l][i];
    end

    csa_level #(.W(W), .M(M)) u_level (
      .vec_i(lin),
      .vec_o(lout)
    );

    for (genvar i = 0; i < N; i++) begin : g_unpack
      if (i < MO) begin : g_v
        assign tree[l+1][i] = lout[i*W +: W];
      end else begin : g_z
        assign tree[l+1][i] = '0;
      end
    end
  end

  rca_adder #(.W(W)) u_cpa (
    .a_i  (tree[H][0]),
    .b_i  (tree[H][1]),
    .sum_o(total)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) sum_q <= total;
    end
  end

  assign sum_o   = sum_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/mop_adder_chk.sv
module mop_adder_chk
  import mop_pkg::*;
#(
  parameter int N = 7,
  parameter int K = 6,
  localparam int W = sum_width(N, K)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic [N*K-1:0] operands_i,
  input logic           valid_o,
  input logic [W-1:0]   sum_o
);
  localparam logic [W-1:0] MAX_SUM = W'(N * ((1 << K) - 1));

  logic [W-1:0] ref_sum;
  always_comb begin
    ref_sum = '0;
    for (int i = 0; i < N; i++) ref_sum = ref_sum + W'(operands_i[i*K +: K]);
  end

  assert_sum_exact_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> sum_o == $past(ref_sum));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_o <= MAX_SUM);

  assert_valid_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_valid_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sum_o));
endmodule

bind mop_csa_tree_adder mop_adder_chk #(.N(N), .K(K)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .operands_i(operands_i),
  .valid_o   (valid_o),
  .sum_o     (sum_o)
);

// File: tb/sim_mop_csa_tree_adder.sv
`timescale 1ns/1ps
module sim_mop_csa_tree_adder;
  localparam int N = 7;
  localparam int K = 6;
  localparam int W = 9;
  localparam int ROWS = 7;

  localparam logic [K-1:0] TBL_OP [ROWS][N] = '{
    '{6'd63, 6'd63, 6'd63, 6'd63, 6'd63, 6'd63, 6'd63},
    '{6'd0,  6'd0,  6'd0,  6'd0,  6'd0,  6'd0,  6'd0},
    '{6'd1,  6'd2,  6'd3,  6'd4,  6'd5,  6'd6,  6'd7},
    '{6'd63, 6'd0,  6'd63, 6'd0,  6'd63, 6'd0,  6'd63},
    '{6'd10, 6'd20, 6'd30, 6'd40, 6'd50, 6'd60, 6'd1},
    '{6'd32, 6'd32, 6'd32, 6'd32, 6'd32, 6'd32, 6'd32},
    '{6'd63, 6'd62, 6'd61, 6'd60, 6'd59, 6'd58, 6'd57}
  };
  localparam int TBL_SUM [ROWS] = '{441, 0, 28, 252, 211, 224, 420};

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           valid_i = 1'b0;
  logic [N*K-1:0] operands_i = '0;
  logic           valid_o;
  logic [W-1:0]   sum_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  mop_csa_tree_adder #(.N(N), .K(K)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .operands_i(operands_i), .valid_o(valid_o), .sum_o(sum_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_row(input int r);
    for (int i = 0; i < N; i++) operands_i[i*K +: K] = TBL_OP[r][i];
  endtask

  function automatic int bsum(input logic [N*K-1:0] ops);
    int s = 0;
    for (int i = 0; i < N; i++) s += int'(ops[i*K +: K]);
    return s;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int held;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check("R1 valid_o in reset", int'(valid_o), 0);
    check("R1 sum_o in reset", int'(sum_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 valid_o after release", int'(valid_o), 0);
    check("R1 sum_o after release", int'(sum_o), 0);

    // table, back-to-back strobes (R2, R3, R4, R6, R7)
    @(negedge clk_i);
    load_row(0);
    valid_i = 1'b1;
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk_i);
      check("R2 R6 table sum", int'(sum_o), TBL_SUM[r]);
      check("R4 valid_o after strobe", int'(valid_o), 1);
      if (r == 0) check("R3 max sum no wrap", int'(sum_o), 441);
      if (r == 1) check("R7 zero after nonzero", int'(sum_o), 0);
      if (r + 1 < ROWS) load_row(r + 1);
    end

    // R5 hold with changing operands
    valid_i = 1'b0;
    held = int'(sum_o);
    load_row(0);
    @(negedge clk_i);
    check("R4 valid_o low", int'(valid_o), 0);
    check("R5 hold sum", int'(sum_o), held);
    load_row(2);
    @(negedge clk_i);
    check("R5 hold sum second", int'(sum_o), held);

    // random operand sets, R2 and R3
    for (int t = 0; t < 200; t++) begin
      int exp_s;
      for (int i = 0; i < N; i++) operands_i[i*K +: K] = K'($urandom);
      exp_s = bsum(operands_i);
      valid_i = 1'b1;
      @(negedge clk_i);
      check("R2 random sum", int'(sum_o), exp_s);
      check("R3 bound", int'(sum_o <= 441), 1);
      if (t % 3 == 0) begin
        valid_i = 1'b0;
        operands_i = '1;
        @(negedge clk_i);
        check("R5 hold after random", int'(sum_o), exp_s);
        check("R4 idle valid_o", int'(valid_o), 0);
      end
    end

    // R7 all-zero after max
    load_row(0);
    valid_i = 1'b1;
    @(negedge clk_i);
    check("R3 max again", int'(sum_o), 441);
    operands_i = '0;
    @(negedge clk_i);
    check("R7 zero operands", int'(sum_o), 0);
    valid_i = 1'b0;
    @(negedge clk_i);

    // R1 reset mid-run
    load_row(6);
    valid_i = 1'b1;
    @(negedge clk_i);
    check("R2 before reset", int'(sum_o), 420);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check("R1 async clear sum", int'(sum_o), 0);
    check("R1 async clear valid", int'(valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after reset", int'(sum_o), 0);

    done = 1'b1;
    finish_run();
  end
endmodule